// File: doc/BRIEF.md
# Prioritized Local Interrupt Combiner

This block gathers a set of level-sensitive interrupt lines from local peripherals into a single interrupt request for the processor. Each line first passes through a two-flop synchronizer. The synchronized levels form the source state. A software-writable enable mask selects which sources may take part. The combined request output is registered and stays high while at least one enabled source is asserted.

Software reaches the block through a small 16-bit register port. It has two mapped offsets. A read of the vector offset does not return the raw source bits. It returns a ready-to-use dispatch code: the lowest-numbered enabled and asserted line `n` is reported as `(n + 1) << 2`, and an idle state reads as zero. The enable mask reads and writes at the second offset. Reads have no side effects, so the read port is combinational from the address. The block has no edge detection, no acknowledge and no nesting. A source stays pending for as long as its line is held high.

Top module: `lirq_combiner`

## Requirements
- R1: Each input line's level is copied into its source bit through two clock stages. A line raised before clock edge k shows in the source state (and so in the vector read) after edge k+1, and is cleared the same way when the line drops.
- R2: The pending set is the source state ANDed bitwise with the enable mask. `irq_out` is a register that is high one clock after the pending set is non-zero and low one clock after it becomes zero.
- R3: A read at byte offset 0x000 returns `(n + 1) << 2`, where n is the lowest-numbered pending line. Higher-numbered pending lines do not change the value.
- R4: The vector read returns 0 when the pending set is empty, including when source bits are asserted but masked off.
- R5: Byte offset 0x002 holds the 16-bit enable mask. A write replaces all 16 bits at the clock edge where `wr_en` is sampled high, and a read returns the stored value. `irq_out` reflects the new mask one clock after that edge.
- R6: Synchronous active-low reset sets the mask to 0x0010, clears the source state and the synchronizer, and drives `irq_out` low, regardless of the input levels.
- R7: Reads of any offset other than 0x000 and 0x002 return 0. Writes to any offset other than 0x002, including the read-only 0x000, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Asynchronous level-sensitive interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data for `addr`, combinational |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
Every single-line and single-mask-bit combination is swept, and several hundred pseudo-random line and mask patterns follow. Each result is compared with a vector and request computed arithmetically in the bench. This catches an encoder that favours the highest line, an off-by-one in the `+1` or the shift, or a mask applied as OR.

The bench times a line's rise and fall edge by edge. A synchronizer with one stage too few or too many would show the vector one cycle early or late, and an unregistered request would rise a cycle early. A mask write is checked against the request one clock later.

Reset is applied with every line held high and checked for the 0x0010 mask. Writes to the vector offset and to unmapped offsets must leave the mask intact, which exposes a loose address decode.

// File: rtl/lirq_pkg.sv
// Package: shared constants for the local interrupt combiner.
// Assumes byte offsets on a 12-bit register window with 16-bit accesses.
package lirq_pkg;
    localparam int unsigned LIRQ_LINES     = 16;
    localparam int unsigned LIRQ_DATA_W    = 16;
    localparam int unsigned LIRQ_ADDR_W    = 12;
    localparam int unsigned LIRQ_VEC_SHIFT = 2;
    localparam logic [LIRQ_ADDR_W-1:0] LIRQ_OFS_VECTOR = 12'h000;
    localparam logic [LIRQ_ADDR_W-1:0] LIRQ_OFS_MASK   = 12'h002;
    localparam logic [LIRQ_DATA_W-1:0] LIRQ_MASK_RST   = 16'h0010;
endpackage

// File: rtl/lirq_sync.sv
// Module: lirq_sync
// Two-flop synchronizer per line; the second stage is the source state.
// Assumes lines are asynchronous levels held for more than two clocks.
module lirq_sync #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] src_o
);
    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] src_q;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            // Capture one line through two flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[g] <= 1'b0;
                    src_q[g]  <= 1'b0;
                end else begin
                    meta_q[g] <= lines_i[g];
                    src_q[g]  <= meta_q[g];
                end
            end
        end
    endgenerate

    assign src_o = src_q;

    // Cycles since reset, saturating at 2, to qualify the latency check.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    // R1: source state equals the line levels two clocks earlier.
    assert_src_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (src_o == $past(lines_i, 2)));
endmodule

// File: rtl/lirq_prio_enc.sv
// Module: lirq_prio_enc
// Encodes the lowest-numbered set bit of the pending set as (n+1)<<SHIFT.
// Assumes the code fits in DATA_W bits; zero means nothing pending.
module lirq_prio_enc #(
    parameter int unsigned LINES     = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned VEC_SHIFT = 2
) (
    input  logic [LINES-1:0]  pend_i,
    output logic [DATA_W-1:0] code_o
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        code_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o = DATA_W'((i + 1) << VEC_SHIFT);
            end
        end
    end
endmodule

// File: rtl/lirq_regs.sv
// Module: lirq_regs
// Holds the enable mask and decodes the register window for reads and writes.
// Assumes full-address decode; unmapped offsets read zero and ignore writes.
module lirq_regs #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFS_VECTOR = '0,
    parameter logic [ADDR_W-1:0] OFS_MASK   = 2,
    parameter logic [DATA_W-1:0] MASK_RST   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] vec_code_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mask_q;
    logic              hit_mask;

    assign hit_mask = (addr == OFS_MASK);

    // Update the enable mask on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= MASK_RST;
        else if (wr_en && hit_mask) mask_q <= wr_data;
    end

    // Select read data by offset; everything else reads zero.
    always_comb begin
        if (addr == OFS_VECTOR)  rd_data = vec_code_i;
        else if (hit_mask)       rd_data = mask_q;
        else                     rd_data = '0;
    end

    assign mask_o = mask_q;

    // R6: reset leaves the mask at its reset value.
    assert_mask_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (mask_o == MASK_RST));

    // R5: a mask write stores the written data.
    assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MASK) |=> (mask_o == $past(wr_data)));

    // R7: writes elsewhere leave the mask untouched.
    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != OFS_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/lirq_combiner.sv
// Module: lirq_combiner (top)
// Synchronizes level lines, masks them, encodes the lowest pending line for
// software and drives a registered combined interrupt request.
// Assumes a single clock domain for the register port.
module lirq_combiner
    import lirq_pkg::*;
#(
    parameter int unsigned LINES     = LIRQ_LINES,
    parameter int unsigned DATA_W    = LIRQ_DATA_W,
    parameter int unsigned ADDR_W    = LIRQ_ADDR_W,
    parameter int unsigned VEC_SHIFT = LIRQ_VEC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out
);
    localparam int unsigned IDX_W = $clog2(LINES + 1);

    logic [LINES-1:0]  src;
    logic [DATA_W-1:0] mask;
    logic [LINES-1:0]  pend;
    logic [DATA_W-1:0] vec_code;
    logic              irq_q;

    lirq_sync #(.LINES(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_in),
        .src_o   (src)
    );

    assign pend = src & mask[LINES-1:0];

    lirq_prio_enc #(
        .LINES     (LINES),
        .DATA_W    (DATA_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_enc (
        .pend_i (pend),
        .code_o (vec_code)
    );

    lirq_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .OFS_VECTOR (LIRQ_OFS_VECTOR),
        .OFS_MASK   (LIRQ_OFS_MASK),
        .MASK_RST   (LIRQ_MASK_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .vec_code_i (vec_code),
        .mask_o     (mask),
        .rd_data    (rd_data)
    );

    // Register the combined request from the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend;
    end

    assign irq_out = irq_q;

    // Assertion helpers: line number decoded back from the vector code.
    logic [IDX_W-1:0] vec_num;
    logic [IDX_W-1:0] vec_sel;
    assign vec_num = vec_code[VEC_SHIFT +: IDX_W];
    assign vec_sel = vec_num - IDX_W'(1);

    // R2: a non-zero encoder result is followed by a raised request.
    assert_irq_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |=> irq_out);

    // R2: a zero encoder result is followed by a dropped request.
    assert_irq_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code == '0) |=> !irq_out);

    // R3: the encoded line is pending and no lower line is.
    assert_vec_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_num != '0) |->
            ((|(pend & (LINES'(1) << vec_sel))) &&
             ((pend & ((LINES'(1) << vec_sel) - LINES'(1))) == '0)));

    // R4: an empty pending set encodes as zero.
    assert_vec_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (vec_code == '0));

    // R6: the request is low in the cycle after reset.
    assert_irq_reset_R6: assert property (@(posedge clk)
        !rst_n |=> !irq_out);
endmodule

// File: tb/lirq_combiner_tb.sv
module lirq_combiner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lirq_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_vec(input logic [15:0] p);
        for (int i = 0; i < 16; i++)
            if (p[i]) return 16'((i + 1) * 4);
        return 16'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 12'h000;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic [15:0] l, input logic [15:0] m, input string req);
        logic [15:0] d;
        @(negedge clk);
        irq_in = l;
        wr(12'h002, m);
        settle();
        rd(12'h000, d);
        chk(req, d, exp_vec(l & m));
        chk("R2", irq_out, |(l & m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [31:0] lfsr;
        // R6: reset with every line high.
        irq_in = 16'hFFFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(12'h002, d); chk("R6", d, 16'h0010);
        rd(12'h000, d); chk("R6", d, 16'h0000);
        chk("R6", irq_out, 1'b0);
        rst_n = 1'b1;
        settle();
        rd(12'h000, d); chk("R6", d, 16'd20);
        chk("R6", irq_out, 1'b1);

        // R1: edge-by-edge latency of a rising then falling line.
        wr(12'h002, 16'hFFFF);
        irq_in = 16'h0000;
        settle();
        irq_in = 16'h0100;
        @(posedge clk); @(negedge clk);
        rd(12'h000, d); chk("R1", d, 16'h0);
        @(posedge clk); @(negedge clk);
        rd(12'h000, d); chk("R1", d, 16'd36);
        chk("R2", irq_out, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R2", irq_out, 1'b1);
        irq_in = 16'h0000;
        @(posedge clk); @(negedge clk);
        rd(12'h000, d); chk("R1", d, 16'd36);
        @(posedge clk); @(negedge clk);
        rd(12'h000, d); chk("R1", d, 16'h0);
        chk("R2", irq_out, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R2", irq_out, 1'b0);

        // R5: mask write timing against the request.
        wr(12'h002, 16'h0000);
        irq_in = 16'h0003;
        settle();
        chk("R4", irq_out, 1'b0);
        rd(12'h000, d); chk("R4", d, 16'h0);
        wr(12'h002, 16'h0002);
        rd(12'h000, d); chk("R5", d, 16'd8);
        chk("R5", irq_out, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R5", irq_out, 1'b1);
        rd(12'h002, d); chk("R5", d, 16'h0002);

        // R7: writes to the vector offset and unmapped offsets are ignored.
        wr(12'h000, 16'hFFFF);
        wr(12'h004, 16'hFFFF);
        wr(12'h003, 16'hFFFF);
        wr(12'hFFE, 16'hFFFF);
        wr(12'h802, 16'hFFFF);
        rd(12'h002, d); chk("R7", d, 16'h0002);
        rd(12'h000, d); chk("R7", d, 16'd8);
        rd(12'h004, d); chk("R7", d, 16'h0);
        rd(12'h001, d); chk("R7", d, 16'h0);
        rd(12'h802, d); chk("R7", d, 16'h0);

        // R3: priority, every line with all higher lines also pending.
        for (int l = 0; l < 16; l++)
            apply(16'hFFFF << l, 16'hFFFF, "R3");

        // R3/R4: single line against single mask bit, exhaustive.
        for (int l = 0; l < 16; l++)
            for (int m = 0; m < 16; m++)
                apply(16'h1 << l, 16'h1 << m, (l == m) ? "R3" : "R4");

        // R3: pseudo-random line and mask patterns.
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[15:0], lfsr[31:16], "R3");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule